// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A single-clock synchronous memory whose read path is pipelined. It behaves like a cache-style burst SRAM. Every address, data and control input passes through an input register on the rising clock edge. An internal 2-bit sequencer produces the later addresses of a four-beat burst. A host-side strobe or a controller-side strobe opens a burst. A step input moves the sequencer on, and an order input picks linear or interleaved beat order. Writes cover the whole word under a write-all control, or cover chosen byte lanes under a lane-enable control with per-lane strobes.

Read data passes through an output register. It therefore appears one clock after the address is registered. The output reads as zero whenever the device is not driving it, which models a released bus. The shared data bus is split into a write-data port and a read-data port.

The block accepts one access on every clock and never stalls. There is no valid/ready handshake and no back-pressure. A caller must take each read word in the cycle it appears, and must not change the order input during a burst.

Top module: `burst_sram`

## Requirements
- R1: Inputs present before clock edge k are captured at edge k. For a read, the word is visible on `rdata` after edge k+1.
- R2: With the device selected, a burst starts and loads the presented address when either `start_host` or `start_ctrl` is high. "Selected" means `cs_main`=1, `cs_aux`=1 and `cs_aux_n`=0. The first beat accesses that address.
- R3: In a non-start cycle of an open burst, `step`=1 advances the beat counter by one, wrapping modulo 4. `step`=0 repeats the previous beat's address.
- R4: `order`=0 (linear) makes the low two address bits of beat n equal to (start + n) mod 4.
- R5: `order`=1 (interleaved) makes the low two address bits of beat n equal to start XOR n.
- R6: The address bits above bit 1 keep their start value for the whole burst.
- R7: `wr_all`=1 on an access writes every byte lane. This holds whatever `wr_lane_en` and `lane_stb` are.
- R8: With `wr_all`=0 and `wr_lane_en`=1, only the lanes whose `lane_stb` bit is 1 are written. Bit i covers `wdata[8i+7:8i]`. With `wr_all`=0 and `wr_lane_en`=0, the access is a read and memory is unchanged.
- R9: `start_host` has no effect while `cs_main`=0; an open burst carries on as if no strobe was given. `start_ctrl` always samples the three chip selects.
- R10: A start strobe taken while the device is not selected closes the burst. `rdata` is zero after the following edge and stays zero until a new burst opens.
- R11: `rdata` is nonzero only when `rd_oe`=1 and the previous registered access was a read. `rd_oe` gates the output combinationally.
- R12: After reset, no burst is open and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| start_host | input | 1 | Host-side burst start strobe, gated by cs_main |
| start_ctrl | input | 1 | Controller-side burst start strobe |
| step | input | 1 | Advance burst counter |
| order | input | 1 | Burst order: 0 linear, 1 interleaved |
| wr_all | input | 1 | Write all lanes |
| wr_lane_en | input | 1 | Enable per-lane writes |
| lane_stb | input | LANES | Per-lane write strobes |
| cs_main | input | 1 | Active-high chip select that also gates start_host |
| cs_aux | input | 1 | Active-high chip select |
| cs_aux_n | input | 1 | Active-low chip select |
| rd_oe | input | 1 | Output enable |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, zero when not driven |

## Verification
Embedded properties check on every cycle the following:
- a loaded burst clears the beat counter;
- an unstepped open burst holds its counter;
- the upper address bits stay frozen between starts;
- a gated host strobe leaves the burst state alone;
- a deselecting strobe or a write leaves `rdata` at zero on the next cycle.

Only the bench's scenarios show that the data is right. These cover the wrap-around of linear and interleaved sequences, partial lane merges against earlier contents, and write-all overriding cleared lane strobes. The bench also checks the exact two-edge latency and the output-enable masking of a read word.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/1ps
package burst_sram_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  typedef struct packed {
    logic host_go;
    logic ctrl_go;
    logic step;
    logic order;
    logic wr_all;
    logic wr_lane_en;
    logic cs_main;
    logic cs_aux;
    logic cs_aux_n;
  } bus_ctl_t;

  // Low two address bits of beat n for a burst that opened at 'first'.
  function automatic logic [1:0] beat_lo(input logic [1:0] first,
                                         input logic [1:0] n,
                                         input logic       ord);
    if (ord == ORD_INTERLEAVE) return first ^ n;
    return first + n;
  endfunction

endpackage

// File: rtl/burst_sram_inreg.sv
`timescale 1ns/1ps
module burst_sram_inreg
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  bus_ctl_t                  ctl_d,
  input  logic [ADDR_W-1:0]         addr_d,
  input  logic [LANES*LANE_W-1:0]   wdata_d,
  input  logic [LANES-1:0]          stb_d,
  output bus_ctl_t                  ctl_q,
  output logic [ADDR_W-1:0]         addr_q,
  output logic [LANES*LANE_W-1:0]   wdata_q,
  output logic [LANES-1:0]          stb_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      stb_q   <= '0;
    end else begin
      ctl_q   <= ctl_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      stb_q   <= stb_d;
    end
  end

endmodule

// File: rtl/burst_sram_addrgen.sv
`timescale 1ns/1ps
module burst_sram_addrgen
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ctl_t          ctl,
  input  logic [ADDR_W-1:0] addr_q,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              access,
  output logic              desel
);

  localparam int HI_W = ADDR_W - 2;

  logic              active;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic [1:0]        cnt_nx;
  logic              sel, go, load, adv;

  always_comb begin
    sel    = ctl.cs_main & ctl.cs_aux & ~ctl.cs_aux_n;
    go     = (ctl.host_go & ctl.cs_main) | ctl.ctrl_go;
    load   = go & sel;
    desel  = go & ~sel;
    adv    = ~go & active & ctl.step;
    cnt_nx = adv ? cnt + 2'd1 : cnt;
    access = load | (~go & active);
    if (load) eff_addr = addr_q;
    else      eff_addr = {base[ADDR_W-1 -: HI_W], beat_lo(base[1:0], cnt_nx, ctl.order)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      cnt    <= '0;
    end else if (load) begin
      active <= 1'b1;
      base   <= addr_q;
      cnt    <= '0;
    end else if (desel) begin
      active <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
    end
  end

  AST_LOAD_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == 2'd0) && active); // R2
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !go && !ctl.step) |=> $stable(cnt)); // R3
  AST_BASE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(base)); // R6
  AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.host_go && !ctl.cs_main && !ctl.ctrl_go) |=> $stable(active) && $stable(base)); // R9
  AST_DESEL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> !active); // R10

endmodule

// File: rtl/burst_sram_array.sv
`timescale 1ns/1ps
module burst_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [LANES-1:0]        lane_mask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    re,
  output logic [LANES*LANE_W-1:0] rd_q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANES*LANE_W-1:0] rd_word;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && lane_mask[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rd_word[g*LANE_W +: LANE_W] = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_q <= '0;
    else if (re) rd_q <= rd_word;
  end

  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (lane_mask != '0)); // R8
  AST_NO_RW_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re)); // R11

endmodule

// File: rtl/burst_sram.sv
`timescale 1ns/1ps
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    start_host,
  input  logic                    start_ctrl,
  input  logic                    step,
  input  logic                    order,
  input  logic                    wr_all,
  input  logic                    wr_lane_en,
  input  logic [LANES-1:0]        lane_stb,
  input  logic                    cs_main,
  input  logic                    cs_aux,
  input  logic                    cs_aux_n,
  input  logic                    rd_oe,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DATA_W = LANES * LANE_W;

  bus_ctl_t            ctl_d, ctl_q;
  logic [ADDR_W-1:0]   addr_q, eff_addr;
  logic [DATA_W-1:0]   wdata_q, rd_q;
  logic [LANES-1:0]    stb_q, lane_mask;
  logic                access, desel, wr_req, rd_req, rd_live;

  always_comb begin
    ctl_d.host_go    = start_host;
    ctl_d.ctrl_go    = start_ctrl;
    ctl_d.step       = step;
    ctl_d.order      = order;
    ctl_d.wr_all     = wr_all;
    ctl_d.wr_lane_en = wr_lane_en;
    ctl_d.cs_main    = cs_main;
    ctl_d.cs_aux     = cs_aux;
    ctl_d.cs_aux_n   = cs_aux_n;
  end

  burst_sram_inreg #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_inreg (
    .clk(clk), .rst_n(rst_n),
    .ctl_d(ctl_d), .addr_d(addr), .wdata_d(wdata), .stb_d(lane_stb),
    .ctl_q(ctl_q), .addr_q(addr_q), .wdata_q(wdata_q), .stb_q(stb_q)
  );

  burst_sram_addrgen #(.ADDR_W(ADDR_W)) u_addrgen (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_q), .addr_q(addr_q),
    .eff_addr(eff_addr), .access(access), .desel(desel)
  );

  always_comb begin
    wr_req    = access & (ctl_q.wr_all | (ctl_q.wr_lane_en & (|stb_q)));
    rd_req    = access & ~wr_req;
    lane_mask = ctl_q.wr_all ? {LANES{1'b1}} : stb_q;
  end

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(wr_req), .lane_mask(lane_mask),
    .addr(eff_addr), .wdata(wdata_q), .re(rd_req), .rd_q(rd_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_live <= 1'b0;
    else        rd_live <= rd_req;
  end

  assign rdata = (rd_oe && rd_live) ? rd_q : '0;

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    desel |=> (rdata == '0)); // R10
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> (rdata == '0)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> (rdata == '0)); // R11

endmodule

// File: tb/burst_sram_tb_top.sv
`timescale 1ns/1ps
module burst_sram_tb_top;

  localparam int AW = 8;
  localparam int LN = 4;
  localparam int LW = 8;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic start_host = 0, start_ctrl = 0, step = 0, order = 0;
  logic wr_all = 0, wr_lane_en = 0, cs_main = 0, cs_aux = 0, cs_aux_n = 1;
  logic rd_oe = 1'b1;
  logic [LN-1:0] lane_stb = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .start_host(start_host),
    .start_ctrl(start_ctrl), .step(step), .order(order), .wr_all(wr_all),
    .wr_lane_en(wr_lane_en), .lane_stb(lane_stb), .cs_main(cs_main),
    .cs_aux(cs_aux), .cs_aux_n(cs_aux_n), .rd_oe(rd_oe), .wdata(wdata),
    .rdata(rdata)
  );

  typedef struct {
    logic [DW-1:0] exp;
    int            due;
    string         tag;
  } item_t;

  item_t q[$];
  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;
  logic oe_next = 1'b1;

  // bench-side model of the requirements
  bit            m_act = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_n = '0;
  logic [DW-1:0] model [256];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {4{a}} ^ 32'h5A3C_96E1;
  endfunction

  task automatic check(input logic [DW-1:0] got, input logic [DW-1:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected=%h", tag, got, exp);
    end
  endtask

  // driver: one bus cycle, pushes the expected read word due two edges later
  task automatic cyc_drive(input bit h, input bit c, input bit st, input bit od,
                           input bit wa, input bit wl, input logic [LN-1:0] sb,
                           input bit c0, input bit c1, input bit c2n,
                           input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input string tag);
    bit sel, go, acc, wr;
    logic [AW-1:0] ea;
    item_t it;
    @(posedge clk); #1;
    start_host = h; start_ctrl = c; step = st; order = od;
    wr_all = wa; wr_lane_en = wl; lane_stb = sb;
    cs_main = c0; cs_aux = c1; cs_aux_n = c2n; addr = a; wdata = d;
    rd_oe = oe_next;
    sel = c0 && c1 && !c2n;
    go  = (h && c0) || c;
    acc = 0; ea = '0;
    if (go) begin
      if (sel) begin m_act = 1; m_base = a; m_n = 0; acc = 1; ea = a; end
      else m_act = 0;
    end else if (m_act) begin
      if (st) m_n = m_n + 2'd1;
      ea = {m_base[AW-1:2], od ? (m_base[1:0] ^ m_n) : (m_base[1:0] + m_n)};
      acc = 1;
    end
    wr = acc && (wa || (wl && (sb != '0)));
    it.exp = '0;
    if (wr) begin
      for (int i = 0; i < LN; i++)
        if (wa || sb[i]) model[ea][i*LW +: LW] = d[i*LW +: LW];
    end else if (acc) begin
      it.exp = model[ea];
    end
    it.due = cyc + 2;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr_word(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    cyc_drive(0, 1, 0, 0, 1, 0, 4'b0000, 1, 1, 0, a, d, tag);
  endtask

  task automatic rd_open(input bit h, input bit od, input logic [AW-1:0] a, input string tag);
    cyc_drive(h, !h, 0, od, 0, 0, 4'b0000, 1, 1, 0, a, '0, tag);
  endtask

  task automatic beat(input bit st, input bit od, input string tag);
    cyc_drive(0, 0, st, od, 0, 0, 4'b0000, 1, 1, 0, '0, '0, tag);
  endtask

  task automatic close_burst(input string tag);
    cyc_drive(0, 1, 0, 0, 0, 0, 4'b0000, 0, 1, 0, '0, '0, tag);
  endtask

  // monitor: compare the output with the scoreboard as results fall due
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      check(rdata, rd_oe ? it.exp : '0, it.tag);
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rdata, '0, "R12 reset output");

    // fill 0x10..0x1F with whole-word writes (write cycles keep output at zero)
    for (int a = 16; a < 32; a++) wr_word(a[AW-1:0], pat(a[AW-1:0]), "R7 R11 fill");
    close_burst("R10 close after fill");

    // linear burst from the host strobe, wraps inside the 4-word block
    rd_open(1, 0, 8'h12, "R1 R2 host start 0x12");
    beat(1, 0, "R4 linear beat1 0x13");
    beat(1, 0, "R4 linear beat2 0x10");
    beat(1, 0, "R6 linear beat3 0x11");
    beat(0, 0, "R3 hold repeats 0x11");
    beat(1, 0, "R3 counter wraps to 0x12");

    // interleaved burst from the controller strobe
    rd_open(0, 1, 8'h16, "R2 ctrl start 0x16");
    beat(1, 1, "R5 interleave beat1 0x17");
    beat(1, 1, "R5 interleave beat2 0x14");
    beat(1, 1, "R5 interleave beat3 0x15");

    // host strobe with cs_main low is ignored; burst keeps reading 0x15
    cyc_drive(1, 0, 0, 1, 0, 0, 4'b0000, 0, 1, 0, 8'h1E, '0, "R9 gated host strobe");
    beat(0, 1, "R9 burst still open");

    // controller strobe with cs_aux low closes the burst
    cyc_drive(0, 1, 0, 0, 0, 0, 4'b0000, 1, 0, 0, 8'h12, '0, "R10 ctrl deselect");
    cyc_drive(0, 0, 1, 0, 0, 0, 4'b0000, 1, 1, 0, '0, '0, "R10 stays idle");

    // partial lane write: lanes 0 and 2 only
    cyc_drive(0, 1, 0, 0, 0, 1, 4'b0101, 1, 1, 0, 8'h11, 32'hFFFF_FFFF, "R8 lane write");
    rd_open(0, 0, 8'h11, "R8 lane merge read 0x11");
    // strobes without lane enable: a read, memory unchanged
    cyc_drive(0, 1, 0, 0, 0, 0, 4'b1111, 1, 1, 0, 8'h13, 32'h0, "R8 no lane enable read");
    rd_open(0, 0, 8'h13, "R8 0x13 unchanged");
    // write-all overrides cleared lane strobes
    cyc_drive(0, 1, 0, 0, 1, 0, 4'b0000, 1, 1, 0, 8'h13, 32'h1234_5678, "R7 write-all");
    rd_open(0, 0, 8'h13, "R7 write-all read back");

    // output enable masks a read word
    rd_open(0, 0, 8'h10, "R11 masked by rd_oe");
    beat(1, 0, "R4 beat after mask");
    oe_next = 1'b0;
    beat(1, 0, "R4 beat 0x12");
    oe_next = 1'b1;
    beat(1, 0, "R4 beat 0x13");

    close_burst("R10 final close");
    for (int i = 0; i < 3; i++) beat(0, 0, "R10 idle");
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule